// File: doc/BRIEF.md
# Burst SPI Master with Programmable Timing

This block is a single-slave SPI master. It moves up to 32 bytes per burst from a transmit FIFO onto MOSI and collects the same number of bytes from MISO into a receive FIFO. A small register-style write port sets the serial clock polarity and phase, the number of system-clock cycles SCLK spends high and spends low, and three chip-select guard times:
- the setup before the first bit,
- the hold after the last bit,
- the quiet gap before the burst counts as finished.

Transmit and receive bit order are chosen separately.

Software fills the transmit FIFO and pulses `start` with a byte count. The master then lowers `cs_n`, clocks the bytes back to back and raises `cs_n` again. It waits out the gap and then pulses `done` for one cycle. Received bytes are read from the receive FIFO, which presents its oldest byte on `rx_data` while it is not empty.

Top module: `spi_burst_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk`, `mosi`, `busy` and `done` are 0, `tx_full` is 0 and `rx_empty` is 1.
- R2: While no burst is shifting bits, `sclk` rests at the polarity bit. The polarity bit is bit 0 of the mode register: 0 means idle low and 1 means idle high. This level holds through setup, hold and gap.
- R3: Each bit has a leading half followed by a trailing half. In the leading half `sclk` equals polarity XOR phase, where phase is bit 1 of the mode register; in the trailing half it is the inverse. MOSI changes at the start of the leading half, so with phase 0 the first bit appears as soon as setup ends, before any SCLK edge. MISO is sampled at the end of the leading half, which is the first edge for phase 0 and the second edge for phase 1.
- R4: Each SCLK high level lasts high+1 system cycles and each low level lasts low+1 cycles, so the duty cycle is set by two separate counts.
- R5: `cs_n` is low for setup+1 cycles before the first bit begins. It stays low for hold+1 cycles after the last bit ends, then stays high for gap+1 cycles before `done`.
- R6: Mode bit 2 selects transmit order: 0 sends bit 7 first and 1 sends bit 0 first.
- R7: Mode bit 3 selects receive order. With 0 the first received bit lands in bit 7; with 1 it lands in bit 0.
- R8: A `start` pulse while idle with a count from 1 to 32 sends that many bytes back to back, taken from the transmit FIFO in order. Each received byte is pushed into the receive FIFO. A count above 32 is treated as 32. `busy` is high from the cycle after `start` until `done`.
- R9: A `start` with count 0 causes no chip-select activity, consumes no transmit byte and gives `done` in the next cycle.
- R10: `done` is high for exactly one cycle, the cycle after the gap ends, and `busy` is low in that cycle.
- R11: Configuration writes are ignored while `busy` is high. The address map is: 0 mode, 1 high count, 2 low count, 3 setup count, 4 hold count, 5 gap count.
- R12: Each FIFO holds 32 bytes. A push into a full transmit FIFO is dropped. `tx_full` and `rx_empty` report the fill state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write value |
| tx_push | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Remove the byte shown on `rx_data` |
| rx_data | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive FIFO empty |
| start | input | 1 | Begin a burst |
| start_len | input | 6 | Burst byte count |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong half-period or guard counter shows up within one SCLK half: `sclk` or `cs_n` changes one cycle early or late relative to the programmed counts. A cycle-accurate pin model catches it on that exact cycle. A bit-index or order error shows up on `mosi` in the first wrongly driven bit. A sampling error shows up only when the receive FIFO is read back after the burst. Gating errors in the configuration or FIFO logic appear one burst later, as timing or data that disagrees with the model's retained settings and queue contents.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int SBM_CW  = 8;                 // timing count width
  localparam int SBM_BW  = 8;                 // bits per serial word
  localparam int SBM_BIW = $clog2(SBM_BW);    // bit index width

  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_HIGH  = 3'd1;
  localparam logic [2:0] A_LOW   = 3'd2;
  localparam logic [2:0] A_SETUP = 3'd3;
  localparam logic [2:0] A_HOLD  = 3'd4;
  localparam logic [2:0] A_GAP   = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_GAP
  } sbm_state_e;

  typedef struct packed {
    logic              rx_lsb;
    logic              tx_lsb;
    logic              cpha;
    logic              cpol;
    logic [SBM_CW-1:0] t_gap;
    logic [SBM_CW-1:0] t_hold;
    logic [SBM_CW-1:0] t_setup;
    logic [SBM_CW-1:0] t_low;
    logic [SBM_CW-1:0] t_high;
  } sbm_cfg_t;
endpackage

// File: rtl/sbm_cfg_regs.sv
module sbm_cfg_regs
  import sbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [SBM_CW-1:0] wr_data,
  input  logic              lock,
  output sbm_cfg_t          cfg
);
  sbm_cfg_t cfg_q, cfg_d;
  logic     wr_ok;

  assign wr_ok = wr_en && !lock;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ok) begin
      case (wr_addr)
        A_MODE: begin
          cfg_d.cpol   = wr_data[0];
          cfg_d.cpha   = wr_data[1];
          cfg_d.tx_lsb = wr_data[2];
          cfg_d.rx_lsb = wr_data[3];
        end
        A_HIGH:  cfg_d.t_high  = wr_data;
        A_LOW:   cfg_d.t_low   = wr_data;
        A_SETUP: cfg_d.t_setup = wr_data;
        A_HOLD:  cfg_d.t_hold  = wr_data;
        A_GAP:   cfg_d.t_gap   = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R11: settings cannot move while a burst was running
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> $stable(cfg_q));
endmodule

// File: rtl/sbm_fifo.sv
module sbm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]  level;
  logic         do_push, do_pop;

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign level   = wp_q - rp_q;
  assign rdata   = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = do_push ? wp_q + 1'b1 : wp_q;
    rp_d = do_pop  ? rp_q + 1'b1 : rp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[AW-1:0]] <= wdata;
  end

  // R12: a push into a full FIFO leaves its contents untouched
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(level)));
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/sbm_engine.sv
module sbm_engine
  import sbm_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  parameter int LEN_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sbm_cfg_t          cfg,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [SBM_BW-1:0] tx_byte,
  input  logic              tx_avail,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [SBM_BW-1:0] rx_byte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy,
  output logic              done
);
  localparam logic [SBM_BIW-1:0] LAST_BIT = SBM_BIW'(SBM_BW - 1);
  localparam logic [LEN_W-1:0]   MAX_LEN  = LEN_W'(MAX_BYTES);

  sbm_state_e        st_q, st_d;
  logic [SBM_CW-1:0] cnt_q, cnt_d;
  logic              half_q, half_d;      // 0 leading, 1 trailing
  logic [SBM_BIW-1:0] bit_q, bit_d;
  logic [LEN_W-1:0]  left_q, left_d;      // bytes after the current one
  logic              sclk_q, sclk_d;
  logic              mosi_q, mosi_d;
  logic              done_q, done_d;
  logic [SBM_BW-1:0] txsr_q, txsr_d;
  logic [SBM_BW-1:0] rxsr_q, rxsr_d;

  logic              lvl_a;
  logic [SBM_CW-1:0] len_a, len_b;
  logic [SBM_BW-1:0] tx_next;
  logic [LEN_W-1:0]  len_eff;

  assign lvl_a   = cfg.cpol ^ cfg.cpha;
  assign len_a   = lvl_a ? cfg.t_high : cfg.t_low;
  assign len_b   = lvl_a ? cfg.t_low  : cfg.t_high;
  assign tx_next = tx_avail ? tx_byte : '0;
  assign len_eff = (start_len > MAX_LEN) ? MAX_LEN : start_len;

  function automatic logic pick(input logic [SBM_BW-1:0] b,
                                input logic [SBM_BIW-1:0] i,
                                input logic lsb);
    return lsb ? b[i] : b[LAST_BIT - i];
  endfunction

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    bit_d   = bit_q;
    left_d  = left_q;
    sclk_d  = sclk_q;
    mosi_d  = mosi_q;
    txsr_d  = txsr_q;
    rxsr_d  = rxsr_q;
    done_d  = 1'b0;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    case (st_q)
      ST_IDLE: begin
        sclk_d = cfg.cpol;
        if (start) begin
          if (len_eff == '0) begin
            done_d = 1'b1;
          end else begin
            st_d   = ST_SETUP;
            cnt_d  = cfg.t_setup;
            left_d = len_eff - LEN_W'(1);
            mosi_d = 1'b0;
          end
        end
      end
      ST_SETUP: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          st_d   = ST_SHIFT;
          half_d = 1'b0;
          bit_d  = '0;
          sclk_d = lvl_a;
          txsr_d = tx_next;
          tx_pop = tx_avail;
          mosi_d = pick(tx_next, '0, cfg.tx_lsb);
          cnt_d  = len_a;
        end
      end
      ST_SHIFT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!half_q) begin
          rxsr_d = cfg.rx_lsb ? {miso, rxsr_q[SBM_BW-1:1]}
                              : {rxsr_q[SBM_BW-2:0], miso};
          half_d = 1'b1;
          sclk_d = ~lvl_a;
          cnt_d  = len_b;
        end else if (bit_q != LAST_BIT) begin
          bit_d  = bit_q + 1'b1;
          half_d = 1'b0;
          sclk_d = lvl_a;
          mosi_d = pick(txsr_q, bit_q + 1'b1, cfg.tx_lsb);
          cnt_d  = len_a;
        end else begin
          rx_push = 1'b1;
          if (left_q != '0) begin
            left_d = left_q - 1'b1;
            bit_d  = '0;
            half_d = 1'b0;
            sclk_d = lvl_a;
            txsr_d = tx_next;
            tx_pop = tx_avail;
            mosi_d = pick(tx_next, '0, cfg.tx_lsb);
            cnt_d  = len_a;
          end else begin
            st_d   = ST_HOLD;
            sclk_d = cfg.cpol;
            cnt_d  = cfg.t_hold;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          st_d  = ST_GAP;
          cnt_d = cfg.t_gap;
        end
      end
      ST_GAP: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      half_q <= 1'b0;
      bit_q  <= '0;
      left_q <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      txsr_q <= '0;
      rxsr_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      bit_q  <= bit_d;
      left_q <= left_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
      txsr_q <= txsr_d;
      rxsr_q <= rxsr_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign done    = done_q;
  assign rx_byte = rxsr_q;
  assign busy    = (st_q != ST_IDLE);
  assign cs_n    = !((st_q == ST_SETUP) || (st_q == ST_SHIFT) || (st_q == ST_HOLD));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: an empty request finishes at once without selecting the slave
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && start_len == '0) |=> (done && cs_n));
  // R2: the select is released with the clock at its resting level
  p_sclk_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (sclk == cfg.cpol));
  // R8: no shifting activity outside a selected burst
  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !tx_pop && !rx_push);
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import sbm_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [SBM_CW-1:0] cfg_wdata,
  input  logic              tx_push,
  input  logic [SBM_BW-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [SBM_BW-1:0] rx_data,
  output logic              rx_empty,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  sbm_cfg_t          cfg;
  logic              tx_empty, tx_pop, rx_push, rx_full;
  logic [SBM_BW-1:0] tx_head, rx_byte;

  sbm_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .lock(busy), .cfg(cfg)
  );

  sbm_fifo #(.W(SBM_BW), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  sbm_fifo #(.W(SBM_BW), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_data), .full(rx_full), .empty(rx_empty)
  );

  sbm_engine #(.MAX_BYTES(DEPTH), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .start(start), .start_len(start_len),
    .tx_byte(tx_head), .tx_avail(!tx_empty), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done)
  );

  // R12: a burst never pushes into a full receive FIFO when the count fits
  p_rx_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push) |-> rx_pop);
endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int LEN_W      = 6;
  localparam int WD_LIMIT   = 100000;

  logic clk, rst_n, cfg_we, tx_push, tx_full, rx_pop, rx_empty;
  logic start, busy, done, sclk, mosi, miso, cs_n;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata, tx_data, rx_data;
  logic [LEN_W-1:0] start_len;

  spi_burst_master #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_empty(rx_empty), .start(start), .start_len(start_len),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0, k = 0, sl_n = 0;
  bit chk_on = 0, finished = 0;
  string cur_req = "R8";
  bit m_cpol = 0, m_cpha = 0, m_txl = 0, m_rxl = 0;
  int m_hi = 0, m_lo = 0, m_su = 0, m_ho = 0, m_gap = 0;
  logic [7:0] txq[$];
  logic [7:0] rxexp[$];
  logic [5:0] expq[$];          // {cs_n, sclk, mosi_valid, mosi, busy, done}
  logic [7:0] sl [32];
  logic prev_sclk, prev_csn;
  logic [5:0] e;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic add(logic cs, logic sc, logic mv, logic mo, logic bz, logic dn, int n);
    repeat (n) expq.push_back({cs, sc, mv, mo, bz, dn});
  endtask

  // cycle-accurate pin model comparison
  always @(negedge clk) begin
    if (chk_on && !finished) begin
      if (expq.size() > 0) begin
        e = expq.pop_front();
        chk({cur_req, " R5 cs_n"}, cs_n, e[5]);
        chk({cur_req, " R3 R4 sclk"}, sclk, e[4]);
        if (e[3]) chk({cur_req, " R6 mosi"}, mosi, e[2]);
        chk({cur_req, " R8 busy"}, busy, e[1]);
        chk({cur_req, " R10 done"}, done, e[0]);
      end else begin
        chk("R5 idle cs_n", cs_n, 1);
        chk("R10 idle done", done, 0);
      end
    end
  end

  // slave: shifts its bytes MSB first, advancing on each edge into the leading level
  always @(negedge clk) begin
    if (!rst_n) begin
      k = 0;
      miso = 1'b0;
    end else begin
      if (prev_csn && !cs_n) k = m_cpha ? -1 : 0;
      else if (!cs_n && sclk !== prev_sclk && sclk == (m_cpol ^ m_cpha)) k++;
      miso = (!cs_n && k >= 0 && k < 8*sl_n) ? sl[k/8][7-(k%8)] : 1'b0;
    end
    prev_sclk = sclk;
    prev_csn  = cs_n;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic cfg_write(logic [2:0] a, logic [7:0] d);
    bit acc;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    acc = !busy;
    @(negedge clk);
    cfg_we = 0;
    if (acc) begin
      case (a)
        3'd0: {m_rxl, m_txl, m_cpha, m_cpol} = d[3:0];
        3'd1: m_hi  = d;
        3'd2: m_lo  = d;
        3'd3: m_su  = d;
        3'd4: m_ho  = d;
        3'd5: m_gap = d;
        default: ;
      endcase
    end
  endtask

  task automatic push_tx(logic [7:0] b);
    tx_push = 1; tx_data = b;
    if (txq.size() < DEPTH) txq.push_back(b);
    @(negedge clk);
    tx_push = 0;
  endtask

  task automatic burst_begin(int n);
    start = 1; start_len = n[LEN_W-1:0];
    @(posedge clk);
    if (n == 0) begin
      add(1, m_cpol, 0, 0, 0, 1, 1);
    end else begin
      int  eff  = (n > DEPTH) ? DEPTH : n;
      bit  la   = m_cpol ^ m_cpha;
      int  lena = la ? m_hi + 1 : m_lo + 1;
      int  lenb = la ? m_lo + 1 : m_hi + 1;
      add(0, m_cpol, 0, 0, 1, 0, m_su + 1);
      for (int b = 0; b < eff; b++) begin
        logic [7:0] tb;
        logic [7:0] sb;
        tb = (txq.size() > 0) ? txq.pop_front() : 8'h00;
        sb = (b < sl_n) ? sl[b] : 8'h00;
        rxexp.push_back(m_rxl ? rev8(sb) : sb);
        for (int j = 0; j < 8; j++) begin
          logic bt;
          bt = m_txl ? tb[j] : tb[7-j];
          add(0, la, 1, bt, 1, 0, lena);
          add(0, !la, 1, bt, 1, 0, lenb);
        end
      end
      add(0, m_cpol, 0, 0, 1, 0, m_ho + 1);
      add(1, m_cpol, 0, 0, 1, 0, m_gap + 1);
      add(1, m_cpol, 0, 0, 0, 1, 1);
    end
    @(negedge clk);
    start = 0;
  endtask

  task automatic burst_wait();
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain_rx();
    while (rxexp.size() > 0) begin
      logic [7:0] x;
      x = rxexp.pop_front();
      chk("R12 rx_empty before read", rx_empty, 0);
      chk("R7 R8 rx_data", rx_data, x);
      rx_pop = 1;
      @(negedge clk);
    end
    rx_pop = 0;
    chk("R12 rx_empty after drain", rx_empty, 1);
  endtask

  task automatic set_slave(int n, logic [7:0] seed);
    sl_n = n;
    for (int i = 0; i < 32; i++) sl[i] = seed + 8'(i * 37);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; tx_push = 0;
    tx_data = 0; rx_pop = 0; start = 0; start_len = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sclk", sclk, 0);
    chk("R1 mosi", mosi, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 rx_empty", rx_empty, 1);
    rst_n = 1;
    @(negedge clk);
    chk_on = 1;

    // mode 0, minimum timings, two bytes
    cur_req = "R3";
    push_tx(8'hA5); push_tx(8'h3C);
    set_slave(2, 8'h96);
    burst_begin(2); burst_wait(); drain_rx();

    // polarity 1, phase 0, uneven duty, longer guards, receive LSB first
    cur_req = "R4";
    cfg_write(3'd0, 8'b1001);
    cfg_write(3'd1, 8'd2); cfg_write(3'd2, 8'd4);
    cfg_write(3'd3, 8'd3); cfg_write(3'd4, 8'd2); cfg_write(3'd5, 8'd5);
    @(negedge clk);
    chk("R2 idle sclk high", sclk, 1);
    push_tx(8'h81); push_tx(8'h4E); push_tx(8'hF0);
    set_slave(3, 8'h1D);
    burst_begin(3); burst_wait(); drain_rx();

    // polarity 0, phase 1, transmit LSB first
    cur_req = "R6";
    cfg_write(3'd0, 8'b0110);
    cfg_write(3'd1, 8'd0); cfg_write(3'd2, 8'd3);
    @(negedge clk);
    chk("R2 idle sclk low", sclk, 0);
    push_tx(8'h2D);
    set_slave(1, 8'hC3);
    burst_begin(1); burst_wait(); drain_rx();

    // polarity 1, phase 1, both LSB first; write during burst must be ignored
    cur_req = "R7";
    cfg_write(3'd0, 8'b1111);
    cfg_write(3'd1, 8'd1); cfg_write(3'd5, 8'd0);
    for (int i = 0; i < 4; i++) push_tx(8'h10 + 8'(i * 29));
    set_slave(4, 8'h5A);
    burst_begin(4);
    repeat (5) @(negedge clk);
    cfg_write(3'd1, 8'd9);      // R11: dropped, model keeps high count 1
    cfg_write(3'd0, 8'b0000);   // R11: dropped
    burst_wait(); drain_rx();
    cur_req = "R11";
    chk("R11 idle sclk unchanged", sclk, 1);
    push_tx(8'h77); push_tx(8'hE1);
    set_slave(2, 8'h0F);
    burst_begin(2); burst_wait(); drain_rx();

    // zero count
    cur_req = "R9";
    burst_begin(0); burst_wait();
    chk("R9 rx_empty", rx_empty, 1);

    // full FIFO: 33rd push dropped, 32-byte burst
    cur_req = "R12";
    cfg_write(3'd0, 8'b0000);
    for (int i = 0; i < 33; i++) begin
      if (i == 32) chk("R12 tx_full", tx_full, 1);
      push_tx(8'h03 + 8'(i * 11));
    end
    set_slave(32, 8'h21);
    burst_begin(32); burst_wait(); drain_rx();
    push_tx(8'hB4);
    set_slave(1, 8'h6E);
    burst_begin(1); burst_wait(); drain_rx();

    // count above 32 is treated as 32
    cur_req = "R8";
    for (int i = 0; i < 32; i++) push_tx(8'(i * 7));
    set_slave(32, 8'h44);
    burst_begin(40); burst_wait(); drain_rx();

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule